// File: doc/BRIEF.md
# Nine-bit multidrop address filter

This block sits behind the receive serializer of a UART on a shared multidrop bus that carries 9-bit characters. The top bit of each character tells address characters (1) from data characters (0). A single listen flag decides what the node passes on. While the flag is set, the node waits to be addressed. While it is clear, the node takes everything on the bus.

When the automatic option is on, the block compares each incoming address character with two addresses. The first is the node's own address, masked by an enable mask. The second is a broadcast address, formed as the bitwise OR of the node address and the mask. A hit on either one clears the flag. When the option is off, only the host clears the flag, so it can inspect address characters itself. The whole filter applies only when 9-bit framing is selected. With any other framing, every character passes and the flag is left alone.

The state machine has two states. `ST_OPEN` means the flag is clear and every character is accepted. `ST_LISTEN` means the flag is set and the node is waiting for an address. It has four transitions:
- OPEN→LISTEN on a host set.
- LISTEN→OPEN on a host clear.
- LISTEN→OPEN on a hardware address hit.
- LISTEN→LISTEN when nothing happens, or when a host set arrives.

A host set has priority over both kinds of clear.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset `listen_flag` is 0 (state `ST_OPEN`) and `acc_valid` is 0.
- R2: While `listen_flag` is 0, every character on `rx_valid` appears on `acc_char` with `acc_valid` high for exactly one clock, on the cycle after the character is presented.
- R3: With `nine_bit_en` = 0, every character is accepted whatever the flag, and characters never change `listen_flag`.
- R4: With `nine_bit_en` = 1 and `listen_flag` = 1, a data character (`rx_char[8]` = 0) is dropped and gives no `acc_valid`.
- R5: With `nine_bit_en` = 1, `listen_flag` = 1 and `auto_en` = 0, an address character (`rx_char[8]` = 1) is accepted and the flag stays 1.
- R6: With `auto_en` = 1 and `listen_flag` = 1, an address character whose low bits equal `node_addr` at every position where `addr_mask` is 1 is accepted, and the flag reads 0 from the next cycle.
- R7: Under the same conditions, an address character that has 0 at every position where `node_addr | addr_mask` is 0 (broadcast) is accepted and clears the flag.
- R8: With `auto_en` = 1 and `listen_flag` = 1, an address character that hits neither address is dropped and the flag stays 1.
- R9: A `host_set_listen` pulse sets the flag on the next cycle, and a `host_clr_listen` pulse clears it. When both arrive in the same cycle, set wins. A character is judged against the flag value held before that cycle's host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nine_bit_en | input | 1 | 9-bit framing selected |
| auto_en | input | 1 | Hardware address match clears the flag |
| node_addr | input | AW | Node address |
| addr_mask | input | AW | Address enable mask |
| host_set_listen | input | 1 | Host write: set the listen flag |
| host_clr_listen | input | 1 | Host write: clear the listen flag |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | AW+1 | Received character, bit AW is the address marker |
| acc_valid | output | 1 | Accepted character strobe, one clock |
| acc_char | output | AW+1 | Accepted character |
| listen_flag | output | 1 | Listen flag state |

## Verification
The bench builds the block with the default address width of 8 bits, node address 0x5A and mask 0xF0. With these values some characters hit only the masked own address (0x53), some hit only the broadcast address (0xFA, 0xA0), and some miss both (0x35, 0x15). That lets the bench separate R6, R7 and R8. A second phase uses an all-zero mask, which turns every address character into an own-address hit.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LISTEN = 1'b1
    } flt_state_e;
endpackage

// File: rtl/mdrop_addr_cmp.sv
module mdrop_addr_cmp #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW-1:0] node_addr,
    input  logic [AW-1:0] addr_mask,
    output logic          own_hit,
    output logic          bcast_hit
);
    logic [AW-1:0] own_bit_ok;
    logic [AW-1:0] bc_bit_ok;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        // masked position must equal the node address bit
        assign own_bit_ok[i] = !addr_mask[i] || (rx_addr[i] == node_addr[i]);
        // broadcast: positions where node|mask is 0 must be 0
        assign bc_bit_ok[i]  = (node_addr[i] | addr_mask[i]) || !rx_addr[i];
    end

    assign own_hit   = &own_bit_ok;
    assign bcast_hit = &bc_bit_ok;
endmodule

// File: rtl/mdrop_flag_fsm.sv
module mdrop_flag_fsm
    import mdrop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_set,
    input  logic host_clr,
    input  logic hw_clr,
    output logic listen
);
    flt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (host_set) state_d = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (host_set)               state_d = ST_LISTEN;
                else if (host_clr || hw_clr) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        listen = (state_q == ST_LISTEN);
    end
endmodule

// File: rtl/mdrop_accept_reg.sv
module mdrop_accept_reg #(
    parameter int AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [AW:0] rx_char,
    input  logic        nine_bit_en,
    input  logic        auto_en,
    input  logic        listen,
    input  logic        own_hit,
    input  logic        bcast_hit,
    output logic        hw_clr,
    output logic        acc_valid,
    output logic [AW:0] acc_char
);
    localparam int MARK = AW;

    logic is_addr;
    logic hit;
    logic take;

    always_comb begin
        is_addr = rx_char[MARK];
        hit     = own_hit || bcast_hit;
        take    = 1'b0;
        hw_clr  = 1'b0;
        if (rx_valid) begin
            if (!nine_bit_en || !listen) begin
                take = 1'b1;
            end else if (is_addr) begin
                take   = !auto_en || hit;
                hw_clr = auto_en && hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_char  <= '0;
        end else begin
            acc_valid <= take;
            if (take) acc_char <= rx_char;
        end
    end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
    parameter int AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nine_bit_en,
    input  logic        auto_en,
    input  logic [AW-1:0] node_addr,
    input  logic [AW-1:0] addr_mask,
    input  logic        host_set_listen,
    input  logic        host_clr_listen,
    input  logic        rx_valid,
    input  logic [AW:0] rx_char,
    output logic        acc_valid,
    output logic [AW:0] acc_char,
    output logic        listen_flag
);
    logic own_hit, bcast_hit, hw_clr;

    mdrop_addr_cmp #(.AW(AW)) cmp_i (
        .rx_addr   (rx_char[AW-1:0]),
        .node_addr (node_addr),
        .addr_mask (addr_mask),
        .own_hit   (own_hit),
        .bcast_hit (bcast_hit)
    );

    mdrop_accept_reg #(.AW(AW)) acc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_char     (rx_char),
        .nine_bit_en (nine_bit_en),
        .auto_en     (auto_en),
        .listen      (listen_flag),
        .own_hit     (own_hit),
        .bcast_hit   (bcast_hit),
        .hw_clr      (hw_clr),
        .acc_valid   (acc_valid),
        .acc_char    (acc_char)
    );

    mdrop_flag_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_set (host_set_listen),
        .host_clr (host_clr_listen),
        .hw_clr   (hw_clr),
        .listen   (listen_flag)
    );
endmodule

// File: rtl/mdrop_filter_checker.sv
module mdrop_filter_checker #(
    parameter int AW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        nine_bit_en,
    input logic        auto_en,
    input logic [AW-1:0] node_addr,
    input logic [AW-1:0] addr_mask,
    input logic        host_set_listen,
    input logic        host_clr_listen,
    input logic        rx_valid,
    input logic [AW:0] rx_char,
    input logic        acc_valid,
    input logic [AW:0] acc_char,
    input logic        listen_flag
);
    logic own_m, bc_m;
    assign own_m = (((rx_char[AW-1:0] ^ node_addr) & addr_mask) == '0);
    assign bc_m  = ((rx_char[AW-1:0] & ~(node_addr | addr_mask)) == '0);

    a_r2_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !listen_flag) |=> (acc_valid && acc_char == $past(rx_char)));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(rx_valid));

    a_r3_flag_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (!nine_bit_en && !host_set_listen && !host_clr_listen) |=> $stable(listen_flag));

    a_r4_drop_data: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_bit_en && listen_flag && rx_valid && !rx_char[AW]) |=> !acc_valid);

    a_r6_r7_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_bit_en && auto_en && listen_flag && rx_valid && rx_char[AW]
         && (own_m || bc_m) && !host_set_listen) |=> (acc_valid && !listen_flag));

    a_r8_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_bit_en && auto_en && listen_flag && rx_valid && rx_char[AW]
         && !own_m && !bc_m && !host_clr_listen) |=> (!acc_valid && listen_flag));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        host_set_listen |=> listen_flag);
endmodule

bind mdrop_addr_filter mdrop_filter_checker #(.AW(AW)) chk_i (.*);

// File: tb/mdrop_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mdrop_addr_filter_tb_top;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nine_bit_en = 1'b0, auto_en = 1'b0;
    logic [AW-1:0] node_addr = 8'h5A, addr_mask = 8'hF0;
    logic host_set_listen = 1'b0, host_clr_listen = 1'b0;
    logic rx_valid = 1'b0;
    logic [AW:0] rx_char = '0;
    logic acc_valid;
    logic [AW:0] acc_char;
    logic listen_flag;

    always #2.5 clk = ~clk;

    mdrop_addr_filter #(.AW(AW)) dut_i (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    bit model_flag = 0;
    logic [AW:0] exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each accept with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && !done && acc_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4/R8 unexpected accept", int'(acc_char), 0);
            end else begin
                logic [AW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(acc_char == e, t, int'(acc_char), int'(e));
            end
        end
    end

    task automatic send(input logic [AW:0] c, input string req);
        bit hit, take;
        @(negedge clk);
        rx_valid = 1'b1;
        rx_char  = c;
        hit  = (((c[AW-1:0] ^ node_addr) & addr_mask) == '0) ||
               ((c[AW-1:0] & ~(node_addr | addr_mask)) == '0);
        take = !nine_bit_en || !model_flag || (c[AW] && (!auto_en || hit));
        if (take) begin
            exp_q.push_back(c);
            tag_q.push_back(req);
        end
        if (nine_bit_en && model_flag && auto_en && c[AW] && hit) model_flag = 0;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic host(input bit s, input bit c);
        @(negedge clk);
        host_set_listen = s;
        host_clr_listen = c;
        if (s) model_flag = 1;
        else if (c) model_flag = 0;
        @(negedge clk);
        host_set_listen = 1'b0;
        host_clr_listen = 1'b0;
    endtask

    task automatic flag_is(input string req);
        @(negedge clk);
        check(listen_flag == model_flag, req, listen_flag, model_flag);
    endtask

    task automatic drain(input string req);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(listen_flag == 1'b0, "R1 flag", listen_flag, 0);
        check(acc_valid == 1'b0, "R1 acc_valid", acc_valid, 0);
        rst_n = 1'b1;
        nine_bit_en = 1'b1;
        // R2: open state passes data and address
        send(9'h012, "R2 data open");
        send(9'h1A5, "R2 addr open");
        drain("R2 drained");
        // R9 set
        host(1, 0); flag_is("R9 set");
        // R4 and R5, manual mode
        send(9'h033, "R4 data dropped");
        send(9'h144, "R5 manual addr");
        drain("R5 drained");
        flag_is("R5 flag kept");
        host(0, 1); flag_is("R9 clear");
        // automatic mode
        auto_en = 1'b1;
        host(1, 0);
        send(9'h135, "R8 miss");
        send(9'h115, "R8 miss2");
        send(9'h077, "R4 data auto");
        flag_is("R8 flag kept");
        send(9'h153, "R6 own hit");
        flag_is("R6 cleared");
        send(9'h0AB, "R2 data after hit");
        drain("R6 drained");
        host(1, 0);
        send(9'h1FA, "R7 broadcast");
        flag_is("R7 cleared");
        host(1, 0);
        send(9'h1A0, "R7 broadcast2");
        flag_is("R7 cleared2");
        host(1, 1); flag_is("R9 set wins");
        // R3: 8-bit framing passes all, flag untouched
        nine_bit_en = 1'b0;
        send(9'h135, "R3 addr");
        send(9'h011, "R3 data");
        send(9'h153, "R3 match ignored");
        drain("R3 drained");
        flag_is("R3 flag kept");
        // zero mask: every address hits own address
        nine_bit_en = 1'b1;
        addr_mask = '0;
        send(9'h1C3, "R6 zero mask");
        flag_is("R6 zero mask cleared");
        drain("R6 final drain");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule